// File: doc/BRIEF.md
# Two-Region Read Port with Address-Dependent Wait States

This block is a bus subordinate on a single-manager AHB-Lite style bus that answers read transfers from two internal regions behind one select line. The low half of its address window is a small zero-latency word store: every read there completes in the cycle right after its address phase, so a run of reads returns one word per clock. The high half is a small register bank modelled as a slow data source: each read there holds the ready output low for a fixed, parameter-set number of cycles before the word is presented.

The address-phase control is registered at the end of each accepted address phase. The data phase then uses only those registered values to pick the region, the word and the byte lanes. The read-data bus carries meaningful data only in the cycle that completes a read, and is held at zero otherwise. Write transfers exist only to preload either region. They always finish with no wait state.

Top module: `twin_region_rd_port`

## Requirements
- R1: After reset, hreadyout is 1, hrdata is 0, and every word in both regions reads as 0.
- R2: An address phase is committed only when hsel is 1, htrans is NONSEQ (2'b10) or SEQ (2'b11), hready is 1 and hreadyout is 1. IDLE (2'b00), BUSY (2'b01) or deselected phases change no storage, and their data phase completes with no wait state and hrdata 0.
- R3: haddr[11] picks the region: 0 is the fast store (16 words, word index haddr[5:2]) and 1 is the slow bank (4 words, word index haddr[3:2]).
- R4: A committed read of the fast store completes in the cycle after its address phase with hreadyout 1 and the data on hrdata. Back-to-back reads return one word per cycle.
- R5: A committed read of the slow bank gives exactly SLOW_WAIT (default 3) cycles with hreadyout 0, then one cycle with hreadyout 1 and the data on hrdata.
- R6: hrdata is 0 in every cycle that is not the completing cycle of a read data phase, including wait cycles and write data phases.
- R7: hsize 3'b000 returns the byte at lane haddr[1:0]. hsize 3'b001 returns the halfword at lane haddr[1]. Any other hsize returns the whole word. Lanes are little-endian (lane k is bits 8k+7..8k), and all unselected lanes are 0.
- R8: A committed write stores the full hwdata word, sampled in its data phase, into the addressed word of either region. It completes with no wait state, and a read whose address phase coincides with that data phase returns the new word.
- R9: While hreadyout is 0, address-phase inputs are ignored even if hready is 1. A transfer offered during a wait cycle is neither stored nor answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | 32 | Byte address (address phase) |
| htrans | input | 2 | Transfer type (address phase) |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size (address phase) |
| hready | input | 1 | Bus-wide ready seen by all subordinates |
| hwdata | input | 32 | Write data (data phase) |
| hrdata | output | 32 | Read data, valid in the completing cycle |
| hreadyout | output | 1 | Low while the current data phase stalls |

## Verification
The properties assume that the manager holds the address-phase signals for a stalled transfer and that the inputs are known after reset. Apart from the R9 check, they also assume hready mirrors hreadyout, as it does with one subordinate on the bus. The stimulus routes hready from hreadyout at all times except a short window inside a slow-bank stall. In that window hready is forced high and a write is offered on purpose, to show it is dropped. Each transfer is issued only after hreadyout has been seen high, so every offered transfer is taken at a known edge.

// File: rtl/trp_pkg.sv
package trp_pkg;

   localparam logic [1:0] TR_IDLE   = 2'b00;
   localparam logic [1:0] TR_BUSY   = 2'b01;
   localparam logic [1:0] TR_NONSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ    = 2'b11;

   localparam logic [2:0] SZ_BYTE = 3'b000;
   localparam logic [2:0] SZ_HALF = 3'b001;

   localparam int BUS_W = 32;

   typedef struct packed {
      logic       valid;
      logic       write;
      logic       slow;
      logic [1:0] lane;
      logic [2:0] size;
   } ph_ctl_t;

endpackage

// File: rtl/trp_addr_stage.sv
module trp_addr_stage
   import trp_pkg::*;
#(
   parameter int REGION_BIT = 11,
   parameter int FIDX_W     = 4,
   parameter int SIDX_W     = 2
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic              hsel,
   input  logic [31:0]       haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic              hready,
   input  logic              hreadyout,
   output ph_ctl_t           ctl,
   output logic [FIDX_W-1:0] fidx,
   output logic [SIDX_W-1:0] sidx,
   output logic              start_slow
);

   logic accept;
   logic spare_unused;

   assign accept     = hsel & ((htrans == TR_NONSEQ) | (htrans == TR_SEQ))
                       & hready & hreadyout;
   assign start_slow = accept & ~hwrite & haddr[REGION_BIT];
   assign spare_unused = ^haddr;

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         ctl  <= '0;
         fidx <= '0;
         sidx <= '0;
      end else if (hreadyout) begin
         ctl.valid <= accept;
         ctl.write <= hwrite;
         ctl.slow  <= haddr[REGION_BIT];
         ctl.lane  <= haddr[1:0];
         ctl.size  <= hsize;
         fidx      <= haddr[2 +: FIDX_W];
         sidx      <= haddr[2 +: SIDX_W];
      end
   end

endmodule

// File: rtl/trp_word_store.sv
module trp_word_store #(
   parameter int DEPTH  = 16,
   parameter int WIDTH  = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             hclk,
   input  logic             hresetn,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/trp_wait_timer.sv
module trp_wait_timer #(
   parameter int WAIT = 3
) (
   input  logic hclk,
   input  logic hresetn,
   input  logic start,
   output logic busy
);

   generate
      if (WAIT == 0) begin : g_nowait
         logic spare_unused;
         assign spare_unused = start ^ hclk ^ hresetn;
         assign busy = 1'b0;
      end else begin : g_count
         localparam int CNT_W = $clog2(WAIT + 1);
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge hclk or negedge hresetn) begin
            if (!hresetn)        cnt <= '0;
            else if (start)      cnt <= LOAD;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end

         assign busy = (cnt != '0);
      end
   endgenerate

endmodule

// File: rtl/trp_lane_align.sv
module trp_lane_align
   import trp_pkg::*;
(
   input  logic [BUS_W-1:0] word,
   input  logic [1:0]       lane,
   input  logic [2:0]       size,
   output logic [BUS_W-1:0] out
);

   logic [BUS_W-1:0] mask;

   always_comb begin
      case (size)
         SZ_BYTE: mask = 32'h0000_00FF << {lane, 3'b000};
         SZ_HALF: mask = 32'h0000_FFFF << {lane[1], 4'b0000};
         default: mask = '1;
      endcase
      out = word & mask;
   end

endmodule

// File: rtl/twin_region_rd_port.sv
module twin_region_rd_port
   import trp_pkg::*;
#(
   parameter int FAST_DEPTH = 16,
   parameter int SLOW_DEPTH = 4,
   parameter int SLOW_WAIT  = 3,
   parameter int REGION_BIT = 11
) (
   input  logic        hclk,
   input  logic        hresetn,
   input  logic        hsel,
   input  logic [31:0] haddr,
   input  logic [1:0]  htrans,
   input  logic        hwrite,
   input  logic [2:0]  hsize,
   input  logic        hready,
   input  logic [31:0] hwdata,
   output logic [31:0] hrdata,
   output logic        hreadyout
);

   localparam int FIDX_W = $clog2(FAST_DEPTH);
   localparam int SIDX_W = $clog2(SLOW_DEPTH);

   generate
      if (FAST_DEPTH < 2 || (FAST_DEPTH & (FAST_DEPTH - 1)) != 0) begin : g_bad_fast
         $error("FAST_DEPTH must be a power of two of at least 2");
      end
      if (SLOW_DEPTH < 2 || (SLOW_DEPTH & (SLOW_DEPTH - 1)) != 0) begin : g_bad_slow
         $error("SLOW_DEPTH must be a power of two of at least 2");
      end
      if (REGION_BIT < 2 + FIDX_W || REGION_BIT < 2 + SIDX_W || REGION_BIT > 31) begin : g_bad_region
         $error("REGION_BIT must lie above both word index fields and inside haddr");
      end
      if (SLOW_WAIT < 0) begin : g_bad_wait
         $error("SLOW_WAIT must not be negative");
      end
   endgenerate

   ph_ctl_t           ctl;
   logic [FIDX_W-1:0] fidx;
   logic [SIDX_W-1:0] sidx;
   logic              start_slow;
   logic              busy;
   logic [BUS_W-1:0]  fast_word;
   logic [BUS_W-1:0]  slow_word;
   logic [BUS_W-1:0]  sel_word;
   logic [BUS_W-1:0]  lane_word;
   logic              we_fast;
   logic              we_slow;

   assign hreadyout = ~busy;

   trp_addr_stage #(
      .REGION_BIT (REGION_BIT),
      .FIDX_W     (FIDX_W),
      .SIDX_W     (SIDX_W)
   ) i_addr (
      .hclk       (hclk),
      .hresetn    (hresetn),
      .hsel       (hsel),
      .haddr      (haddr),
      .htrans     (htrans),
      .hwrite     (hwrite),
      .hsize      (hsize),
      .hready     (hready),
      .hreadyout  (hreadyout),
      .ctl        (ctl),
      .fidx       (fidx),
      .sidx       (sidx),
      .start_slow (start_slow)
   );

   assign we_fast = ctl.valid & ctl.write & ~ctl.slow;
   assign we_slow = ctl.valid & ctl.write &  ctl.slow;

   trp_word_store #(.DEPTH(FAST_DEPTH), .WIDTH(BUS_W)) i_fast (
      .hclk    (hclk),
      .hresetn (hresetn),
      .we      (we_fast),
      .idx     (fidx),
      .wdata   (hwdata),
      .rdata   (fast_word)
   );

   trp_word_store #(.DEPTH(SLOW_DEPTH), .WIDTH(BUS_W)) i_slow (
      .hclk    (hclk),
      .hresetn (hresetn),
      .we      (we_slow),
      .idx     (sidx),
      .wdata   (hwdata),
      .rdata   (slow_word)
   );

   trp_wait_timer #(.WAIT(SLOW_WAIT)) i_timer (
      .hclk    (hclk),
      .hresetn (hresetn),
      .start   (start_slow),
      .busy    (busy)
   );

   assign sel_word = ctl.slow ? slow_word : fast_word;

   trp_lane_align i_lane (
      .word (sel_word),
      .lane (ctl.lane),
      .size (ctl.size),
      .out  (lane_word)
   );

   assign hrdata = (ctl.valid & ~ctl.write & hreadyout) ? lane_word : '0;

endmodule

// File: rtl/trp_checker.sv
module trp_checker #(
   parameter int SLOW_WAIT  = 3,
   parameter int REGION_BIT = 11
) (
   input logic        hclk,
   input logic        hresetn,
   input logic        hsel,
   input logic [31:0] haddr,
   input logic [1:0]  htrans,
   input logic        hwrite,
   input logic        hready,
   input logic        hreadyout,
   input logic [31:0] hrdata
);

   localparam logic [15:0] WAIT_L = 16'(SLOW_WAIT);

   logic        commit;
   logic        slow_hit;
   logic [15:0] low_run;
   logic        spare_unused;

   assign commit   = hsel && htrans[1] && hready && hreadyout;
   assign slow_hit = haddr[REGION_BIT];
   assign spare_unused = ^haddr;

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn)        low_run <= '0;
      else if (!hreadyout) low_run <= low_run + 16'd1;
      else                 low_run <= '0;
   end

   generate
      if (SLOW_WAIT > 0) begin : g_stall_start
         assert_slow_stall_start_R5: assert property (@(posedge hclk) disable iff (!hresetn)
            (commit && !hwrite && slow_hit) |=> !hreadyout);
      end
   endgenerate

   assert_stall_bound_R5: assert property (@(posedge hclk) disable iff (!hresetn)
      low_run <= WAIT_L);

   assert_stall_length_R5: assert property (@(posedge hclk) disable iff (!hresetn)
      (hreadyout && low_run != 16'd0) |-> low_run == WAIT_L);

   assert_fast_zero_wait_R4: assert property (@(posedge hclk) disable iff (!hresetn)
      (commit && !hwrite && !slow_hit) |=> hreadyout);

   assert_write_zero_wait_R8: assert property (@(posedge hclk) disable iff (!hresetn)
      (commit && hwrite) |=> (hreadyout && hrdata == 32'd0));

   assert_quiet_in_stall_R6: assert property (@(posedge hclk) disable iff (!hresetn)
      !hreadyout |-> hrdata == 32'd0);

   assert_idle_okay_R2: assert property (@(posedge hclk) disable iff (!hresetn)
      (hreadyout && !commit) |=> (hreadyout && hrdata == 32'd0));

endmodule

bind twin_region_rd_port trp_checker #(
   .SLOW_WAIT  (SLOW_WAIT),
   .REGION_BIT (REGION_BIT)
) i_trp_checker (
   .hclk      (hclk),
   .hresetn   (hresetn),
   .hsel      (hsel),
   .haddr     (haddr),
   .htrans    (htrans),
   .hwrite    (hwrite),
   .hready    (hready),
   .hreadyout (hreadyout),
   .hrdata    (hrdata)
);

// File: tb/test_twin_region_rd_port.sv
module test_twin_region_rd_port;

   localparam int CLK_PERIOD = 10;
   localparam int NWAIT      = 3;
   localparam logic [31:0] SLOW_BASE = 32'h0000_0800;

   logic        hclk = 1'b0;
   logic        hresetn = 1'b0;
   logic        hsel = 1'b0;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hwrite = 1'b0;
   logic [2:0]  hsize = 3'b010;
   logic [31:0] hwdata = '0;
   logic [31:0] hrdata;
   logic        hreadyout;
   logic        force_rdy = 1'b0;
   logic        hready_in;

   assign hready_in = force_rdy ? 1'b1 : hreadyout;

   always #(CLK_PERIOD / 2) hclk = ~hclk;

   twin_region_rd_port #(.SLOW_WAIT(NWAIT)) i_twin_region_rd_port (
      .hclk      (hclk),
      .hresetn   (hresetn),
      .hsel      (hsel),
      .haddr     (haddr),
      .htrans    (htrans),
      .hwrite    (hwrite),
      .hsize     (hsize),
      .hready    (hready_in),
      .hwdata    (hwdata),
      .hrdata    (hrdata),
      .hreadyout (hreadyout)
   );

   typedef struct {
      logic [31:0] data;
      int          waits;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   int          stalls = 0;
   bit          done = 1'b0;
   logic [31:0] fast_m [16];
   logic [31:0] slow_m [4];
   logic [31:0] pend_wd = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   function automatic logic [31:0] lanes(input logic [31:0] w, input logic [1:0] a, input logic [2:0] s);
      if (s == 3'b000) begin
         case (a)
            2'd0: return {24'h0, w[7:0]};
            2'd1: return {16'h0, w[15:8], 8'h0};
            2'd2: return {8'h0, w[23:16], 16'h0};
            default: return {w[31:24], 24'h0};
         endcase
      end
      if (s == 3'b001) return a[1] ? {w[31:16], 16'h0} : {16'h0, w[15:0]};
      return w;
   endfunction

   // Drive one address phase, wait until it is taken, queue its expected data phase.
   task automatic drive(input bit sel, input logic [1:0] tr, input bit wr,
                        input logic [31:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, input string tag);
      exp_t it;
      bit   com;
      hsel   = sel;
      htrans = tr;
      hwrite = wr;
      haddr  = a;
      hsize  = sz;
      hwdata = pend_wd;
      pend_wd = wd;
      @(negedge hclk);
      while (!hreadyout) @(negedge hclk);
      @(posedge hclk);
      #1;
      com = sel && tr[1];
      it.tag = tag;
      it.data = '0;
      it.waits = 0;
      if (com && wr) begin
         if (a[11]) slow_m[a[3:2]] = wd;
         else       fast_m[a[5:2]] = wd;
      end else if (com) begin
         it.data  = lanes(a[11] ? slow_m[a[3:2]] : fast_m[a[5:2]], a[1:0], sz);
         it.waits = a[11] ? NWAIT : 0;
      end
      q.push_back(it);
   endtask

   task automatic rd(input logic [31:0] a, input logic [2:0] sz, input string tag);
      drive(1'b1, 2'b10, 1'b0, a, sz, '0, tag);
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
      drive(1'b1, 2'b10, 1'b1, a, 3'b010, d, tag);
   endtask

   task automatic idle();
      drive(1'b0, 2'b00, 1'b0, '0, 3'b010, '0, "idle R2");
   endtask

   // Scoreboard monitor: compares each data phase away from the clock edge.
   always @(negedge hclk) begin
      if (hresetn && q.size() > 0) begin
         if (!hreadyout) begin
            stalls++;
            chk(hrdata == 32'd0, "R6 zero during stall", hrdata, 32'd0);
         end else begin
            exp_t it;
            it = q.pop_front();
            chk(hrdata == it.data, {it.tag, " data"}, hrdata, it.data);
            chk(stalls == it.waits, {it.tag, " wait count"}, 32'(stalls), 32'(it.waits));
            stalls = 0;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) fast_m[i] = '0;
      for (int i = 0; i < 4; i++)  slow_m[i] = '0;
      repeat (3) @(posedge hclk);
      #1 hresetn = 1'b1;
      @(negedge hclk);
      chk(hreadyout == 1'b1, "R1 reset hreadyout", 32'(hreadyout), 32'd1);
      chk(hrdata == 32'd0, "R1 reset hrdata", hrdata, 32'd0);
      @(posedge hclk);
      #1;
      rd(32'h0000_0014, 3'b010, "R1 fast word after reset");
      rd(SLOW_BASE + 32'h4, 3'b010, "R1 slow word after reset");

      // R8 preload both regions back to back
      for (int i = 0; i < 6; i++) wr(32'(i * 4), 32'hA000_0000 + 32'(i * 32'h0101_0101), "R8 fast write");
      for (int i = 0; i < 4; i++) wr(SLOW_BASE + 32'(i * 4), 32'h5100_0000 + 32'(i * 32'h0011_2233), "R8 slow write");

      // R4 / R3 fast reads, one per cycle
      for (int i = 0; i < 6; i++) rd(32'(i * 4), 3'b010, "R4 fast read");
      // R5 / R3 slow reads, back to back then fast after slow
      for (int i = 3; i >= 0; i--) rd(SLOW_BASE + 32'(i * 4), 3'b010, "R5 slow read");
      rd(32'h4, 3'b010, "R4 fast after slow");
      rd(SLOW_BASE, 3'b010, "R5 slow after fast");

      // R7 byte and halfword lanes
      wr(32'h8, 32'hDDCC_BBAA, "R8 lane pattern");
      for (int b = 0; b < 4; b++) rd(32'h8 + 32'(b), 3'b000, "R7 byte lane");
      rd(32'h8, 3'b001, "R7 low halfword");
      rd(32'hA, 3'b001, "R7 high halfword");
      rd(SLOW_BASE + 32'hB, 3'b000, "R7 slow byte lane");
      rd(SLOW_BASE + 32'hE, 3'b001, "R7 slow halfword");

      // R2 uncommitted transfers leave storage alone
      drive(1'b1, 2'b00, 1'b1, 32'h8, 3'b010, 32'h1111_1111, "R2 idle write");
      drive(1'b1, 2'b01, 1'b1, 32'h8, 3'b010, 32'h2222_2222, "R2 busy write");
      drive(1'b0, 2'b10, 1'b1, 32'h8, 3'b010, 32'h3333_3333, "R2 deselected write");
      drive(1'b1, 2'b00, 1'b0, SLOW_BASE, 3'b010, '0, "R2 idle slow read");
      rd(32'h8, 3'b010, "R2 storage unchanged");

      // R8 read whose address phase is the write's data phase
      wr(32'h3C, 32'hCAFE_F00D, "R8 write before read");
      rd(32'h3C, 3'b010, "R8 read after write");
      wr(SLOW_BASE + 32'h8, 32'h0BAD_BEEF, "R8 slow write before read");
      rd(SLOW_BASE + 32'h8, 3'b010, "R8 slow read after write");
      drive(1'b1, 2'b11, 1'b0, 32'h3C, 3'b010, '0, "R2 SEQ read committed");

      // R9 transfer offered during a stall with hready forced high is dropped
      rd(SLOW_BASE + 32'h4, 3'b010, "R9 slow read carrying stall");
      force_rdy = 1'b1;
      hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h0; hsize = 3'b010;
      hwdata = 32'hBAD0_BAD0;
      @(posedge hclk); #1;
      @(posedge hclk); #1;
      hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
      force_rdy = 1'b0;
      idle();
      rd(32'h0, 3'b010, "R9 word untouched by stalled offer");

      idle();
      idle();
      while (q.size() > 0) @(negedge hclk);
      @(negedge hclk);
      chk(hreadyout == 1'b1, "R2 quiet end hreadyout", 32'(hreadyout), 32'd1);
      finish_run();
   end

endmodule